// File: doc/BRIEF.md
# Five-Stage CIC Decimation Filter

This block is a multiplier-free low-pass decimator for a stream of 16-bit two's-complement samples. Each accepted sample is registered, then shifted left by a programmable growth amount into a 66-bit accumulator word. This headroom keeps the filtered result from overflowing. Five cascaded integrators run once per valid input sample. Their widths narrow from 66 to 26 bits, and each stage keeps only the upper part of its predecessor's result.

An internal rate divider counts valid samples and raises a decimated strobe once every R samples. On that strobe, five first-difference comb stages process the 26-bit integrator output. A rounding register then reduces the comb output to a saturated 16-bit result with a one-cycle valid pulse. Every integrator and every comb stage can be disabled on its own. A bypass control sends the shifted input straight to the rounding register at the input rate.

Top module: `cic5_decimator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: Each valid sample is registered and then sign-extended and shifted left by `growth` (legal range 0 to 50) into a 66-bit word. In bypass with `growth` = 50, the output equals the input sample exactly.
- R3: Integrator stage k (k = 0..4) is 66 − 10k bits wide and wraps on overflow. The input to stage k > 0 is bits [75−10k:10] of stage k−1. All integrators advance only on cycles where a registered valid sample is present and bypass is low.
- R4: One `out_valid` pulse is produced per `dec_rate` valid samples. A `dec_rate` value below 4 acts as 4.
- R5: On each decimated strobe, comb stage k outputs its input minus that input's value at the previous strobe, wrapped to 26 bits. With `growth` = 40 and `dec_rate` = 4, a constant input settles to an output equal to that input.
- R6: Clearing `int_en[k]` makes integrator k load its input without feedback. Clearing `comb_en[k]` makes comb k pass its input unchanged while its delay register still updates. Bit 0 is the first stage.
- R7: With bypass low, `out_valid` goes high for one cycle at the second rising edge after the edge that samples the dec_rate-th `in_valid`.
- R8: The 26-bit result is rounded half-up on its 10 low bits (adding 512, then shifting right arithmetically). Results above 32767 saturate to 32767.
- R9: With bypass high, each valid sample produces an output at the next rising edge after it is sampled. That output is bits [65:40] of the shifted word, rounded as in R8. Integrators and divider hold their state.
- R10: Idle cycles between valid samples do not change any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Two's-complement input sample |
| in_valid | input | 1 | Sample qualifier |
| growth | input | 6 | Left shift applied before integration |
| dec_rate | input | 6 | Decimation factor R |
| bypass | input | 1 | Send shifted input straight to the rounding register |
| int_en | input | 5 | Per-integrator feedback enable |
| comb_en | input | 5 | Per-comb subtraction enable |
| out_data | output | 16 | Rounded, saturated result |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
The bench goes after these corners:
- **Truncation between narrowing integrator stages.** A slice taken one bit off gives outputs that drift from an arithmetic model only under large-gain settings.
- **The divider boundary.** An off-by-one count changes the number of outputs per burst. A missing clamp for rates below 4 makes outputs far too frequent.
- **Half-up rounding of negative halves.** A design that rounds away from zero returns −2 instead of −1 for −1.5.
- **Saturation.** The bench searches for a rate and constant input whose wrapped steady state lies just under the 26-bit limit. A design without the clamp returns −32768 there instead of 32767.
- **Sparse and gapped input.** These expose any stage that advances on idle cycles.

// File: rtl/cic5_pkg.sv
package cic5_pkg;

  // Round half-up by dropping 'drop' low bits, then clamp to a signed 'ow'-bit range.
  function automatic logic [31:0] round_sat(input logic signed [63:0] v,
                                            input int drop, input int ow);
    logic signed [63:0] r;
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    r  = (v + (64'sd1 <<< (drop - 1))) >>> drop;
    hi = (64'sd1 <<< (ow - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (ow - 1));
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r[31:0];
  endfunction

endpackage

// File: rtl/cic5_integrator.sv
module cic5_integrator #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= en ? (acc_q + din) : din;
  end

  // R3: an integrator never moves without a valid non-bypass sample
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));

endmodule

// File: rtl/cic5_rate_divider.sv
module cic5_rate_divider #(
  parameter int RATE_W   = 6,
  parameter int MIN_RATE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] rate_eff;
  logic [RATE_W-1:0] cnt_q;

  assign rate_eff = (rate < RATE_W'(MIN_RATE)) ? RATE_W'(MIN_RATE) : rate;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (step) begin
        if (cnt_q >= rate_eff - RATE_W'(1)) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + RATE_W'(1);
        end
      end
    end
  end

  // R4: with a minimum rate of 4, strobes are never back to back
  a_r4_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R4: a strobe only follows an accepted sample
  a_r4_tick_after_step: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(step));

endmodule

// File: rtl/cic5_comb_chain.sv
module cic5_comb_chain #(
  parameter int W = 26,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [N-1:0][W-1:0] dly_q;
  logic [W-1:0]        stg [N+1];

  assign stg[0] = din;

  for (genvar k = 0; k < N; k++) begin : g_comb
    assign stg[k+1] = en[k] ? (stg[k] - dly_q[k]) : stg[k];

    always_ff @(posedge clk) begin
      if (rst)       dly_q[k] <= '0;
      else if (tick) dly_q[k] <= stg[k];
    end
  end

  assign dout = stg[N];

  // R5: comb memory only changes on the decimated strobe
  a_r5_delay_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dly_q));

endmodule

// File: rtl/cic5_decimator.sv
module cic5_decimator #(
  parameter int IN_W     = 16,
  parameter int ACC_W    = 66,
  parameter int STAGES   = 5,
  parameter int TRIM     = 10,
  parameter int OUT_W    = 16,
  parameter int RATE_W   = 6,
  parameter int SHIFT_W  = 6,
  parameter int MIN_RATE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IN_W-1:0]    in_data,
  input  logic               in_valid,
  input  logic [SHIFT_W-1:0] growth,
  input  logic [RATE_W-1:0]  dec_rate,
  input  logic               bypass,
  input  logic [STAGES-1:0]  int_en,
  input  logic [STAGES-1:0]  comb_en,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_valid
);
  import cic5_pkg::*;

  localparam int COMB_W = ACC_W - (STAGES - 1) * TRIM;
  localparam int RND    = COMB_W - OUT_W;

  logic [IN_W-1:0]   in_q;
  logic              in_vq;
  logic [ACC_W-1:0]  shifted;
  logic [ACC_W-1:0]  stage_q [STAGES];
  logic              step;
  logic              tick;
  logic [COMB_W-1:0] integ_out;
  logic [COMB_W-1:0] comb_out;
  logic [COMB_W-1:0] byp_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      in_vq <= 1'b0;
    end else begin
      in_vq <= in_valid;
      if (in_valid) in_q <= in_data;
    end
  end

  assign shifted  = {{(ACC_W-IN_W){in_q[IN_W-1]}}, in_q} << growth;
  assign step     = in_vq & ~bypass;
  assign byp_word = shifted[ACC_W-1 -: COMB_W];

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    localparam int W = ACC_W - k * TRIM;
    logic [W-1:0] din;
    logic [W-1:0] q;
    if (k == 0) begin : g_first
      assign din = shifted;
    end else begin : g_next
      assign din = stage_q[k-1][W+TRIM-1:TRIM];
    end
    cic5_integrator #(.W(W)) u_int (
      .clk(clk), .rst(rst), .step(step), .en(int_en[k]), .din(din), .acc_q(q)
    );
    if (W < ACC_W) begin : g_pad
      assign stage_q[k] = {{(ACC_W-W){1'b0}}, q};
    end else begin : g_full
      assign stage_q[k] = q;
    end
  end

  assign integ_out = stage_q[STAGES-1][COMB_W-1:0];

  cic5_rate_divider #(.RATE_W(RATE_W), .MIN_RATE(MIN_RATE)) u_div (
    .clk(clk), .rst(rst), .step(step), .rate(dec_rate), .tick(tick)
  );

  cic5_comb_chain #(.W(COMB_W), .N(STAGES)) u_comb (
    .clk(clk), .rst(rst), .tick(tick), .en(comb_en), .din(integ_out), .dout(comb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (bypass) begin
      out_valid <= in_vq;
      if (in_vq)
        out_data <= OUT_W'(round_sat(64'(signed'(byp_word)), RND, OUT_W));
    end else begin
      out_valid <= tick;
      if (tick)
        out_data <= OUT_W'(round_sat(64'(signed'(comb_out)), RND, OUT_W));
    end
  end

  // R9: in bypass every registered sample yields a result one edge later
  a_r9_bypass_echo: assert property (@(posedge clk) disable iff (rst)
    (bypass && in_vq) |=> out_valid);

  // R7: in filter mode a result only appears after a decimated strobe
  a_r7_out_after_tick: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(bypass)) |-> $past(tick));

  // R1: nothing is emitted without a registered sample behind it
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_vq) && !$past(tick)) |-> !out_valid);

endmodule

// File: tb/cic5_decimator_tb.sv
`timescale 1ns/1ps
module cic5_decimator_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic [5:0]  growth = '0;
  logic [5:0]  dec_rate = 6'd4;
  logic        bypass = 1'b0;
  logic [4:0]  int_en = 5'h1f;
  logic [4:0]  comb_en = 5'h1f;
  logic [15:0] out_data;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int exp_q[$];
  int last_out = 0;
  string cur_req = "R3";

  logic signed [65:0] m_acc [5];
  logic signed [65:0] m_dly [5];
  int m_cnt;

  always #2.5 clk = ~clk;

  cic5_decimator u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .growth(growth), .dec_rate(dec_rate), .bypass(bypass),
    .int_en(int_en), .comb_en(comb_en), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [65:0] wrapw(input logic signed [65:0] v, input int w);
    logic signed [65:0] t;
    t = v <<< (66 - w);
    return t >>> (66 - w);
  endfunction

  function automatic int rnd(input logic signed [65:0] v);
    logic signed [65:0] r;
    r = (v + 66'sd512) >>> 10;
    if (r > 66'sd32767)  return 32767;
    if (r < -66'sd32768) return -32768;
    return int'(r);
  endfunction

  function automatic int reff();
    return (dec_rate < 4) ? 4 : int'(dec_rate);
  endfunction

  task automatic model_sample(input logic signed [15:0] x);
    logic signed [65:0] sx;
    logic signed [65:0] inp;
    logic signed [65:0] v;
    logic signed [65:0] y;
    sx = wrapw($signed({{50{x[15]}}, x}) <<< growth, 66);
    if (bypass) begin
      exp_q.push_back(rnd(sx >>> 40));
      return;
    end
    for (int k = 4; k >= 0; k--) begin
      inp = (k == 0) ? sx : wrapw(m_acc[k-1] >>> 10, 66 - 10*k);
      m_acc[k] = wrapw(int_en[k] ? m_acc[k] + inp : inp, 66 - 10*k);
    end
    m_cnt++;
    if (m_cnt == reff()) begin
      m_cnt = 0;
      v = m_acc[4];
      for (int k = 0; k < 5; k++) begin
        y = comb_en[k] ? v - m_dly[k] : v;
        m_dly[k] = v;
        v = wrapw(y, 26);
      end
      exp_q.push_back(rnd(v));
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      last_out = int'($signed(out_data));
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, last_out, 99999);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(last_out == e, cur_req, last_out, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    exp_q.delete();
    for (int k = 0; k < 5; k++) begin
      m_acc[k] = '0;
      m_dly[k] = '0;
    end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input logic signed [15:0] x, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    model_sample(x);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic run_config(input bit byp, input int g, input int r,
                            input logic [4:0] ie, input logic [4:0] ce,
                            input int n, input int maxgap, input string req);
    bypass = byp; growth = 6'(g); dec_rate = 6'(r); int_en = ie; comb_en = ce;
    cur_req = req;
    do_reset();
    for (int i = 0; i < n; i++)
      send(16'($urandom), (maxgap == 0) ? 0 : int'($urandom_range(0, maxgap)));
    drain(req);
  endtask

  initial begin
    #(5.0 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R1", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 16'h0, "R1", int'(out_data), 0);

    // R2: bypass with full shift echoes the input
    bypass = 1'b1; growth = 6'd50; cur_req = "R2";
    do_reset();
    send(-16'sd32768, 0); send(-16'sd1, 0); send(16'sd0, 0);
    send(16'sd1, 0); send(16'sd12345, 0); send(16'sd32767, 0);
    drain("R2");
    check(last_out == 32767, "R2", last_out, 32767);

    // R8: half-up rounding, exhaustive small sweep at growth 49
    growth = 6'd49; cur_req = "R8";
    do_reset();
    for (int x = -40; x <= 40; x++) send(16'(x), 0);
    drain("R8");
    do_reset();
    send(-16'sd3, 1);
    drain("R8");
    check(last_out == -1, "R8", last_out, -1);
    send(16'sd3, 1);
    drain("R8");
    check(last_out == 2, "R8", last_out, 2);

    // R9: bypass output one edge after sampling, integrators frozen
    growth = 6'd50; cur_req = "R9";
    do_reset();
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd77; model_sample(16'sd77);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R9", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R9", int'(out_valid), 1);
    drain("R9");
    run_config(1'b1, 45, 4, 5'h1f, 5'h1f, 60, 2, "R9");

    // R5: DC gain at growth 40, rate 4
    bypass = 1'b0; growth = 6'd40; dec_rate = 6'd4; cur_req = "R5";
    int_en = 5'h1f; comb_en = 5'h1f;
    do_reset();
    for (int i = 0; i < 48; i++) send(16'sd1000, 0);
    drain("R5");
    check(last_out == 1000, "R5", last_out, 1000);

    // R3 / R5: random data, continuous valid, several rates
    run_config(1'b0, 40, 4, 5'h1f, 5'h1f, 400, 0, "R3");
    run_config(1'b0, 36, 7, 5'h1f, 5'h1f, 700, 0, "R3");
    run_config(1'b0, 30, 16, 5'h1f, 5'h1f, 1600, 0, "R5");
    run_config(1'b0, 20, 63, 5'h1f, 5'h1f, 3200, 0, "R3");

    // R10: gaps in the sample stream
    run_config(1'b0, 36, 7, 5'h1f, 5'h1f, 500, 3, "R10");

    // R6: stage enables
    run_config(1'b0, 40, 5, 5'b10110, 5'b01101, 400, 1, "R6");
    run_config(1'b0, 44, 6, 5'b00000, 5'b11111, 300, 0, "R6");

    // R4: rate clamp and output count
    bypass = 1'b0; growth = 6'd40; dec_rate = 6'd2; cur_req = "R4";
    do_reset();
    for (int i = 0; i < 20; i++) send(16'sd500, 0);
    check(exp_q.size() <= 5, "R4", exp_q.size(), 5);
    drain("R4");
    run_config(1'b0, 40, 0, 5'h1f, 5'h1f, 40, 1, "R4");

    // R7: latency of the decimated output
    dec_rate = 6'd4; cur_req = "R7";
    do_reset();
    for (int i = 0; i < 3; i++) send(16'sd200, 2);
    @(negedge clk); in_valid = 1'b1; in_data = 16'sd200; model_sample(16'sd200);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7", int'(out_valid), 1);
    drain("R7");

    // R8: saturation via a wrapped steady state just under the 26-bit limit
    begin
      int fr;
      int fx;
      longint g5;
      longint v;
      fr = 0; fx = 0;
      for (int r = 5; r <= 20 && fr == 0; r++) begin
        g5 = longint'(r) * r * r * r * r;
        for (int x = -32768; x <= 32767; x++) begin
          v = (g5 * x) % 67108864;
          if (v < 0) v += 67108864;
          if (v >= 33554432) v -= 67108864;
          if (v >= 33553920 && fr == 0) begin
            fr = r; fx = x;
          end
        end
      end
      if (fr != 0) begin
        bypass = 1'b0; growth = 6'd40; dec_rate = 6'(fr); cur_req = "R8";
        do_reset();
        for (int i = 0; i < 10 * fr; i++) send(16'(fx), 0);
        drain("R8");
        check(last_out == 32767, "R8", last_out, 32767);
      end else begin
        $display("note: no saturating constant found for R8");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule